// File: doc/BRIEF.md
# Serial Port with Holding Registers and Overrun Tracking

This block is a byte-wide asynchronous serial port that a small processor drives through three word-wide registers: a status word, a data port and a rate word. A byte written to the data port waits in a one-byte holding register. It moves into a shift register at the next bit boundary and leaves on `txd` as a frame with one start bit, eight data bits and one stop bit. The receiver watches `rxd` through a synchronizer. It times each frame from the falling edge of the start bit and samples every bit near its middle. A frame with a valid stop bit is placed in a receive register for the processor to read.

The bit rate comes from two counters in series, both clocked by the system clock. The first counter produces a sampling tick, which the receiver uses for its mid-bit timing. The second counter counts sampling ticks and produces the bit tick that paces the transmitter. When a byte leaves the holding register, the block gives a one-cycle transmit pulse. When a good frame lands in the receive register, it gives a one-cycle receive pulse. The status word also records whether an unread byte was replaced by a newer one.

Top module: `sio_uart`

## Requirements
- R1: The status word is at address 0. Bit 0 is high while the transmit shifter is idle, bit 1 is high while the holding register is empty, bit 2 is receive-full and bit 3 is overrun; the upper bits read as zero. After reset the status word reads 0x0003 and `txd` is high.
- R2: A byte in the holding register moves to the shifter on the first bit tick at which the shifter is idle or is finishing its stop bit. In the cycle after that tick, `tx_irq` is high for exactly one cycle and status bit 1 reads high.
- R3: The transmitter sends a low start bit, then the eight data bits LSB first, then a high stop bit, each lasting one bit period. `txd` stays high when there is nothing to send.
- R4: A write to the data port (address 1) while status bit 1 is low is dropped: it changes neither the frame being sent nor the byte that is waiting.
- R5: The rate word is at address 2 and can be read back. Bits 15..8 (A) set the first stage, which gives one sampling tick every A+1 clocks. Bits 7..0 (B) set the second stage, which makes one bit last B+1 sampling ticks, so a bit is (A+1)(B+1) clocks. Writing the rate word restarts both counters. The reset value is 0x0107.
- R6: Idle `rxd` is high. After a high-to-low transition on `rxd`, the receiver checks the start bit at (B>>1)+1 sampling ticks. It then samples each data bit B+1 ticks after the previous sample and shifts the bits in LSB first. If the stop bit samples high, the byte is readable at address 1, status bit 2 is set and `rx_irq` pulses for one cycle.
- R7: On each accepted frame, status bit 3 takes the value status bit 2 held just before that frame completed.
- R8: A read of address 1 clears status bit 2 and leaves bit 3 unchanged.
- R9: A frame whose stop bit samples low is dropped. It raises no `rx_irq` and leaves the receive byte and status bits 2 and 3 unchanged.
- R10: A start bit that is high again at its check point is ignored. The receiver then goes back to waiting for a falling edge and receives the next full frame normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading the data port clears receive-full) |
| bus_addr | input | 2 | Register select: 0 status, 1 data, 2 rate |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| tx_irq | output | 1 | One-cycle pulse when the holding register empties |
| rx_irq | output | 1 | One-cycle pulse when a good frame is stored |

## Verification
A bad rate counter shows up on `txd` within one frame: bit lengths drift from (A+1)(B+1) clocks, and the bench's cycle-exact model catches this on the first mismatching clock. A holding register or shifter that is out of step shows up in the same cycle as a wrong `tx_irq`, a wrong status bit 0/1 or a wrong line level. Receiver state errors, such as a mis-timed sample, lost bits or a wrong overrun copy, appear at the end of the affected frame. They show as a wrong byte at address 1, a missing or extra `rx_irq`, or wrong status bits 2 and 3.

// File: rtl/sio_pkg.sv
package sio_pkg;

   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd0;
   localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
   localparam logic [ADDR_W-1:0] ADDR_RATE = 2'd2;

   localparam int ST_SH_IDLE = 0;
   localparam int ST_HR_EMPTY = 1;
   localparam int ST_RX_FULL = 2;
   localparam int ST_RX_OVR = 3;
   localparam int ST_BITS = 4;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [DIV_W-1:0] div_a,
   input  logic [DIV_W-1:0] div_b,
   output logic             tick_smp,
   output logic             tick_bit
);

   logic [DIV_W-1:0] cnt_a;
   logic [DIV_W-1:0] cnt_b;

   assign tick_smp = (cnt_a == div_a);
   assign tick_bit = tick_smp && (cnt_b == div_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_a <= '0;
         cnt_b <= '0;
      end else if (clr) begin
         cnt_a <= '0;
         cnt_b <= '0;
      end else begin
         if (tick_smp) begin
            cnt_a <= '0;
            cnt_b <= (cnt_b == div_b) ? '0 : cnt_b + DIV_W'(1);
         end else begin
            cnt_a <= cnt_a + DIV_W'(1);
         end
      end
   end

   a_r5_first_stage_bound : assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> cnt_a <= div_a);
   a_r5_second_stage_bound : assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> cnt_b <= div_b);
   a_r5_second_holds_between : assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_smp && !clr) |=> $stable(cnt_b));

endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_bit,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              txd,
   output logic              hr_empty,
   output logic              sh_idle,
   output logic              tx_irq
);

   localparam int FRAME_W = DATA_W + 2;
   localparam int CNT_W = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

   logic [DATA_W-1:0]  hold_q;
   logic               hold_full;
   logic [FRAME_W-1:0] shift_q;
   logic               busy;
   logic [CNT_W-1:0]   bit_cnt;
   logic               on_last;
   logic               load;

   assign on_last = busy && (bit_cnt == LAST_BIT);
   assign load = tick_bit && hold_full && (!busy || on_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= '0;
         hold_full <= 1'b0;
         shift_q   <= '1;
         busy      <= 1'b0;
         bit_cnt   <= '0;
         tx_irq    <= 1'b0;
      end else begin
         tx_irq <= load;
         if (wr_en && !hold_full) begin
            hold_q    <= wr_data;
            hold_full <= 1'b1;
         end
         if (load) begin
            shift_q   <= {1'b1, hold_q, 1'b0};
            bit_cnt   <= '0;
            busy      <= 1'b1;
            hold_full <= 1'b0;
         end else if (busy && tick_bit) begin
            shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
            bit_cnt <= bit_cnt + CNT_W'(1);
            if (on_last) busy <= 1'b0;
         end
      end
   end

   assign txd      = shift_q[0];
   assign hr_empty = !hold_full;
   assign sh_idle  = !busy;

   a_r2_irq_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |=> !tx_irq);
   a_r2_irq_with_empty : assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> (hr_empty && !sh_idle && !txd));
   a_r3_idle_line_high : assert property (@(posedge clk) disable iff (!rst_n)
      sh_idle |-> txd);
   a_r4_frame_untouched : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick_bit) |=> $stable(shift_q));
   a_r4_held_byte_kept : assert property (@(posedge clk) disable iff (!rst_n)
      (hold_full && !load) |=> $stable(hold_q));

endmodule

// File: rtl/sio_rx.sv
module sio_rx
   import sio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd,
   input  logic              tick_smp,
   input  logic [DIV_W-1:0]  div_b,
   input  logic              rd_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              rx_ovr,
   output logic              rx_irq
);

   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   line;
   logic                   line_prev;
   logic                   fall;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[g] <= 1'b1;
            else        sync_q[g] <= rxd;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[g] <= 1'b1;
            else        sync_q[g] <= sync_q[g-1];
         end
      end
   end

   assign line = sync_q[SYNC_STAGES-1];
   assign fall = line_prev && !line;

   rx_state_e         state;
   logic [DIV_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] shift_q;
   logic [DIV_W-1:0]  half_pt;
   logic              bit_end;
   logic              stop_bad;

   assign half_pt  = div_b >> 1;
   assign bit_end  = tick_smp && (cnt == div_b);
   assign stop_bad = (state == RX_STOP) && bit_end && !line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_prev <= 1'b1;
         state     <= RX_IDLE;
         cnt       <= '0;
         idx       <= '0;
         shift_q   <= '0;
         rx_data   <= '0;
         rx_full   <= 1'b0;
         rx_ovr    <= 1'b0;
         rx_irq    <= 1'b0;
      end else begin
         line_prev <= line;
         rx_irq    <= 1'b0;
         if (rd_clr) rx_full <= 1'b0;
         unique case (state)
            RX_IDLE: begin
               if (fall) begin
                  state <= RX_START;
                  cnt   <= '0;
               end
            end
            RX_START: begin
               if (tick_smp) begin
                  if (cnt == half_pt) begin
                     cnt   <= '0;
                     idx   <= '0;
                     state <= line ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + DIV_W'(1);
                  end
               end
            end
            RX_DATA: begin
               if (tick_smp) begin
                  if (cnt == div_b) begin
                     cnt     <= '0;
                     shift_q <= {line, shift_q[DATA_W-1:1]};
                     idx     <= idx + IDX_W'(1);
                     if (idx == LAST_IDX) state <= RX_STOP;
                  end else begin
                     cnt <= cnt + DIV_W'(1);
                  end
               end
            end
            RX_STOP: begin
               if (tick_smp) begin
                  if (cnt == div_b) begin
                     cnt   <= '0;
                     state <= RX_IDLE;
                     if (line) begin
                        rx_data <= shift_q;
                        rx_full <= 1'b1;
                        rx_ovr  <= rx_full;
                        rx_irq  <= 1'b1;
                     end
                  end else begin
                     cnt <= cnt + DIV_W'(1);
                  end
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   a_r6_irq_sets_full : assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> rx_full);
   a_r6_irq_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |=> !rx_irq);
   a_r7_overrun_copy : assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> (rx_ovr == $past(rx_full)));
   a_r8_clear_by_read : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_full) |-> $past(rd_clr));
   a_r8_overrun_kept : assert property (@(posedge clk) disable iff (!rst_n)
      !rx_irq |-> $stable(rx_ovr));
   a_r9_bad_stop_dropped : assert property (@(posedge clk) disable iff (!rst_n)
      stop_bad |=> (!rx_irq && $stable(rx_data) && $stable(rx_ovr)));
   a_r10_wait_for_edge : assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_IDLE && !fall) |=> state == RX_IDLE);

endmodule

// File: rtl/sio_uart.sv
module sio_uart
   import sio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int RATE_RESET  = 'h0107
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [2*DIV_W-1:0] bus_wdata,
   output logic [2*DIV_W-1:0] bus_rdata,
   input  logic              rxd,
   output logic              txd,
   output logic              tx_irq,
   output logic              rx_irq
);

   localparam int BUS_W = 2 * DIV_W;

   if (DATA_W < 5 || DATA_W > BUS_W) begin : g_bad_data_w
      $error("sio_uart: DATA_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sio_uart: SYNC_STAGES must be at least 2");
   end
   if (DIV_W < 2) begin : g_bad_div_w
      $error("sio_uart: DIV_W must be at least 2");
   end

   logic [BUS_W-1:0]  rate_q;
   logic              rate_wr;
   logic              data_wr;
   logic              data_rd;
   logic              tick_smp;
   logic              tick_bit;
   logic              hr_empty;
   logic              sh_idle;
   logic [DATA_W-1:0] rx_data;
   logic              rx_full;
   logic              rx_ovr;

   assign rate_wr = bus_wr && (bus_addr == ADDR_RATE);
   assign data_wr = bus_wr && (bus_addr == ADDR_DATA);
   assign data_rd = bus_rd && (bus_addr == ADDR_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rate_q <= BUS_W'(RATE_RESET);
      else if (rate_wr) rate_q <= bus_wdata;
   end

   sio_baud #(.DIV_W(DIV_W)) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (rate_wr),
      .div_a    (rate_q[BUS_W-1:DIV_W]),
      .div_b    (rate_q[DIV_W-1:0]),
      .tick_smp (tick_smp),
      .tick_bit (tick_bit)
   );

   sio_tx #(.DATA_W(DATA_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_bit (tick_bit),
      .wr_en    (data_wr),
      .wr_data  (bus_wdata[DATA_W-1:0]),
      .txd      (txd),
      .hr_empty (hr_empty),
      .sh_idle  (sh_idle),
      .tx_irq   (tx_irq)
   );

   sio_rx #(.DATA_W(DATA_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .rxd      (rxd),
      .tick_smp (tick_smp),
      .div_b    (rate_q[DIV_W-1:0]),
      .rd_clr   (data_rd),
      .rx_data  (rx_data),
      .rx_full  (rx_full),
      .rx_ovr   (rx_ovr),
      .rx_irq   (rx_irq)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_STAT: begin
            bus_rdata[ST_SH_IDLE]  = sh_idle;
            bus_rdata[ST_HR_EMPTY] = hr_empty;
            bus_rdata[ST_RX_FULL]  = rx_full;
            bus_rdata[ST_RX_OVR]   = rx_ovr;
         end
         ADDR_DATA: bus_rdata[DATA_W-1:0] = rx_data;
         ADDR_RATE: bus_rdata = rate_q;
         default:   bus_rdata = '0;
      endcase
   end

   a_r1_reset_lines : assert property (@(posedge clk) disable iff (!rst_n)
      (sh_idle && hr_empty) |-> txd);
   a_r5_rate_kept : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rate_wr) |-> $stable(rate_q));

endmodule

// File: tb/tb_sio_uart.sv
module tb_sio_uart;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        rxd = 1'b1;
   logic        txd;
   logic        tx_irq;
   logic        rx_irq;

   int n_chk = 0;
   int n_bad = 0;
   int rx_pulses = 0;
   int tx_pulses = 0;
   int bit_clks = 16;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sio_uart dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rxd(rxd), .txd(txd), .tx_irq(tx_irq), .rx_irq(rx_irq)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // behavioural model of the transmit path and rate counters
   int m_a = 1, m_b = 7, m_ca = 0, m_cb = 0;
   bit m_full = 0, m_irq = 0;
   int m_hold = 0;
   bit m_line[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_a = 1; m_b = 7; m_ca = 0; m_cb = 0;
         m_full = 0; m_irq = 0; m_hold = 0;
         m_line.delete();
      end else begin
         bit t_smp, t_bit, was_full;
         t_smp = (m_ca == m_a);
         t_bit = t_smp && (m_cb == m_b);
         was_full = m_full;
         m_irq = 0;
         if (bus_wr && bus_addr == 2'd2) begin
            m_a = bus_wdata[15:8]; m_b = bus_wdata[7:0]; m_ca = 0; m_cb = 0;
         end else if (t_smp) begin
            m_ca = 0;
            m_cb = (m_cb == m_b) ? 0 : m_cb + 1;
         end else begin
            m_ca = m_ca + 1;
         end
         if (t_bit) begin
            if (m_line.size() > 0) void'(m_line.pop_front());
            if (m_line.size() == 0 && was_full) begin
               m_line.push_back(1'b0);
               for (int i = 0; i < 8; i++) m_line.push_back(m_hold[i]);
               m_line.push_back(1'b1);
               m_full = 0;
               m_irq = 1;
            end
         end
         if (bus_wr && bus_addr == 2'd1 && !was_full) begin
            m_hold = bus_wdata[7:0];
            m_full = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit exp_txd;
         exp_txd = (m_line.size() > 0) ? m_line[0] : 1'b1;
         chk(txd == exp_txd, "R3", "txd level", txd, exp_txd);
         chk(tx_irq == m_irq, "R2", "tx_irq", tx_irq, m_irq);
         if (bus_addr == 2'd0)
            chk(bus_rdata[1:0] == {!m_full, m_line.size() == 0}, "R1",
                "status bits 1:0", bus_rdata[1:0], {!m_full, m_line.size() == 0});
         if (rx_irq) rx_pulses++;
         if (tx_irq) tx_pulses++;
      end
   end

   task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_addr = 2'd0;
   endtask

   task automatic bus_read(input logic [1:0] a, input bit strobe, output logic [15:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_rd = strobe;
      @(negedge clk);
      d = bus_rdata;
      @(posedge clk); #1;
      bus_rd = 1'b0; bus_addr = 2'd0;
   endtask

   task automatic drive_bit(input logic v, input int n);
      @(posedge clk); #1;
      rxd = v;
      repeat (n - 1) @(posedge clk);
   endtask

   task automatic send_frame(input logic [7:0] b, input bit good_stop);
      drive_bit(1'b0, bit_clks);
      for (int i = 0; i < 8; i++) drive_bit(b[i], bit_clks);
      drive_bit(good_stop, bit_clks);
      drive_bit(1'b1, 2 * bit_clks);
   endtask

   task automatic wait_status(input logic [15:0] mask, input logic [15:0] val);
      logic [15:0] s;
      for (int k = 0; k < 2000; k++) begin
         bus_read(2'd0, 1'b0, s);
         if ((s & mask) == val) return;
      end
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] r;
      int base, lowc;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(bus_rdata == 16'h0003, "R1", "reset status", bus_rdata, 16'h0003);
      chk(txd == 1'b1, "R1", "reset txd", txd, 1);
      bus_read(2'd2, 1'b0, r);
      chk(r == 16'h0107, "R5", "reset rate word", r, 16'h0107);

      // receive: first byte
      send_frame(8'hA5, 1'b1);
      chk(rx_pulses == 1, "R6", "rx_irq count", rx_pulses, 1);
      bus_read(2'd0, 1'b0, r);
      chk(r[3:2] == 2'b01, "R6", "full set, no overrun", r[3:2], 2'b01);
      // second byte left unread -> overrun
      send_frame(8'h3C, 1'b1);
      bus_read(2'd0, 1'b0, r);
      chk(r[3:2] == 2'b11, "R7", "overrun from old full", r[3:2], 2'b11);
      bus_read(2'd1, 1'b1, r);
      chk(r[7:0] == 8'h3C, "R6", "newest byte kept", r[7:0], 8'h3C);
      bus_read(2'd0, 1'b0, r);
      chk(r[3:2] == 2'b10, "R8", "read clears full only", r[3:2], 2'b10);
      // next frame after a read -> overrun drops
      send_frame(8'h0F, 1'b1);
      bus_read(2'd0, 1'b0, r);
      chk(r[3:2] == 2'b01, "R7", "overrun cleared by frame", r[3:2], 2'b01);
      bus_read(2'd1, 1'b1, r);
      chk(r[7:0] == 8'h0F, "R6", "LSB-first byte", r[7:0], 8'h0F);

      // bad stop bit
      base = rx_pulses;
      send_frame(8'h77, 1'b0);
      chk(rx_pulses == base, "R9", "no irq on bad stop", rx_pulses, base);
      bus_read(2'd0, 1'b0, r);
      chk(r[3:2] == 2'b00, "R9", "flags untouched", r[3:2], 2'b00);
      bus_read(2'd1, 1'b0, r);
      chk(r[7:0] == 8'h0F, "R9", "byte untouched", r[7:0], 8'h0F);

      // glitch start bit
      base = rx_pulses;
      drive_bit(1'b0, 3);
      drive_bit(1'b1, 3 * bit_clks);
      chk(rx_pulses == base, "R10", "glitch ignored", rx_pulses, base);
      send_frame(8'h81, 1'b1);
      chk(rx_pulses == base + 1, "R10", "frame after glitch", rx_pulses, base + 1);
      bus_read(2'd1, 1'b1, r);
      chk(r[7:0] == 8'h81, "R10", "byte after glitch", r[7:0], 8'h81);

      // transmit: back-to-back with dropped writes
      base = tx_pulses;
      bus_write(2'd1, 16'h00A5);
      bus_write(2'd1, 16'h005A);
      wait_status(16'h0002, 16'h0002);
      bus_write(2'd1, 16'h003C);
      bus_write(2'd1, 16'h0099);
      wait_status(16'h0003, 16'h0003);
      chk(tx_pulses == base + 2, "R4", "only accepted bytes sent", tx_pulses, base + 2);

      // new rate: A=1, B=5 -> 12 clocks per bit
      bus_write(2'd2, 16'h0105);
      bit_clks = 12;
      bus_read(2'd2, 1'b0, r);
      chk(r == 16'h0105, "R5", "rate readback", r, 16'h0105);
      bus_write(2'd1, 16'h00E1);
      lowc = 0;
      for (int k = 0; k < 200 && txd; k++) @(negedge clk);
      while (!txd && lowc < 100) begin
         lowc++;
         @(negedge clk);
      end
      chk(lowc == 12, "R5", "start bit length", lowc, 12);
      wait_status(16'h0003, 16'h0003);
      send_frame(8'h6B, 1'b1);
      bus_read(2'd1, 1'b1, r);
      chk(r[7:0] == 8'h6B, "R5", "receive at new rate", r[7:0], 8'h6B);

      // fastest second stage: A=3, B=0 -> 4 clocks per bit on transmit
      bus_write(2'd2, 16'h0300);
      bus_write(2'd1, 16'h0055);
      wait_status(16'h0003, 16'h0003);
      chk(tx_pulses == base + 4, "R2", "tx_irq per byte", tx_pulses, base + 4);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule